// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the system reset for a chip from two requests: a digital supply-good level coming from an analog comparator outside the block, and a single-cycle timeout pulse from a watchdog. Reset is asserted as soon as the synchronised supply-good level is low. It stays asserted while that level is low. It is released only after the supply has been good without a break for a programmable number of clock cycles. A watchdog timeout applies the same hold interval. A timeout that arrives while reset is already held starts the interval again.

While reset is held, the block raises an inhibit output that tells the serial command front end to drop every instruction. The block also keeps a volatile cause flag. Software sets and clears it with two command strobes, and the flag lets software tell a watchdog recovery apart from a power-loss recovery. The flag is cleared by the power-on reset. Its strobes are disregarded while the inhibit is raised. The reset output polarity is chosen by a parameter when the block is built.

The supply-good input is asynchronous and passes through a flip-flop synchroniser. The watchdog pulse and the flag strobes are already in the clock domain. All pins are plain level or strobe signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `supply_reset_seq`

## Requirements
- R1: When `supply_good_i` falls, the reset output is asserted after the third rising clock edge that follows the change. It stays asserted for as long as the input stays low.
- R2: After `supply_good_i` rises, reset is released after rising edge number HOLD_CYCLES+2 and not earlier.
- R3: A dropout of `supply_good_i` during the hold interval restarts the count. Release then comes HOLD_CYCLES+2 edges after the last rise.
- R4: While `rst_n` is low, and from its release, the reset output is asserted. It remains asserted until the supply-good condition of R2 has been met.
- R5: With supply good, a one-cycle `wdog_expire_i` pulse asserts reset after that edge. Reset stays asserted for exactly HOLD_CYCLES edges counted from the pulse edge.
- R6: A watchdog pulse that arrives while reset is held restarts the hold count from that edge. Pulses are not queued.
- R7: `cmd_inhibit_o` is 1 in exactly the cycles in which reset is asserted.
- R8: `cause_flag_o` is 0 after `rst_n`. `flag_set_i` makes it 1 after the next edge and `flag_clr_i` makes it 0 after the next edge. When both strobes are high together, clear wins.
- R9: Flag strobes given while reset is asserted leave `cause_flag_o` unchanged.
- R10: With RST_ACTIVE_LOW=1, `sys_rst_o` is 0 when reset is asserted and 1 when it is released. With RST_ACTIVE_LOW=0 the levels are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_good_i | input | 1 | Debounced supply-above-threshold level, asynchronous |
| wdog_expire_i | input | 1 | One-cycle watchdog timeout strobe |
| flag_set_i | input | 1 | Command strobe that sets the cause flag |
| flag_clr_i | input | 1 | Command strobe that clears the cause flag |
| sys_rst_o | output | 1 | System reset, polarity set by RST_ACTIVE_LOW |
| cmd_inhibit_o | output | 1 | High while command instructions must be ignored |
| cause_flag_o | output | 1 | Volatile software cause flag |

## Verification
The release logic is driven with four supply patterns. A clean rise pins the exact release edge. A steady-good interval after release shows that nothing re-asserts reset spuriously. A brownout pins the assertion latency through the synchroniser. A single-cycle dropout in mid-count shows that the count restarts and is not simply paused. Watchdog stimulus is applied once as an isolated pulse, which measures the hold length, and once as a second pulse during the hold, which separates restarting from ignoring or queueing. The flag is driven with set, clear and both strobes together while running, and again while reset is held. This shows the clear priority and the gating. Two instances of opposite polarity share the stimulus, so that an inverted output cannot pass.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Sequencer phases: supply below threshold, counting the hold, running.
  typedef enum logic [1:0] {
    SEQ_SUPPLY_LOW = 2'd0,
    SEQ_HOLD       = 2'd1,
    SEQ_RUN        = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic wdog_expire_i,
  output logic rst_act_o
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!supply_ok_i) begin
      state_d = SEQ_SUPPLY_LOW;
      cnt_d   = '0;
    end else if (wdog_expire_i) begin
      state_d = SEQ_HOLD;
      cnt_d   = '0;
    end else if (state_q != SEQ_RUN) begin
      if (cnt_q == LAST) begin
        state_d = SEQ_RUN;
        cnt_d   = '0;
      end else begin
        state_d = SEQ_HOLD;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_SUPPLY_LOW;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rst_act_o = (state_q != SEQ_RUN);

  // R1: a low synchronised supply level forces reset on the next edge
  assert_low_forces_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> rst_act_o);

  // R5: a watchdog strobe forces reset on the next edge
  assert_wdog_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |=> rst_act_o);

  // R6: a watchdog strobe during the hold leaves the counter at its start
  assert_wdog_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_expire_i && supply_ok_i) |=> (cnt_q == '0) && (state_q == SEQ_HOLD));

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (!blocked_i) begin
      if (clr_i)           flag_q <= 1'b0;
      else if (set_i)      flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R8: clear wins and takes effect on the next edge
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked_i && clr_i) |=> !flag_o);

  // R8: set alone takes effect on the next edge
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked_i && set_i && !clr_i) |=> flag_o);

  // R9: strobes are disregarded while reset is held
  assert_flag_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_i |=> $stable(flag_o));

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int HOLD_CYCLES    = 25_000_000,
  parameter int SYNC_STAGES    = 2,
  parameter bit RST_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good_i,
  input  logic wdog_expire_i,
  input  logic flag_set_i,
  input  logic flag_clr_i,
  output logic sys_rst_o,
  output logic cmd_inhibit_o,
  output logic cause_flag_o
);

  localparam int RUN_W = $clog2(HOLD_CYCLES + 1);

  logic supply_ok;
  logic rst_act;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (supply_good_i),
    .sync_o  (supply_ok)
  );

  rstseq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok),
    .wdog_expire_i (wdog_expire_i),
    .rst_act_o     (rst_act)
  );

  rstseq_cause u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked_i (rst_act),
    .set_i     (flag_set_i),
    .clr_i     (flag_clr_i),
    .flag_o    (cause_flag_o)
  );

  generate
    if (RST_ACTIVE_LOW) begin : g_pol_low
      assign sys_rst_o = ~rst_act;
    end else begin : g_pol_high
      assign sys_rst_o = rst_act;
    end
  endgenerate

  assign cmd_inhibit_o = rst_act;

  // Checker: consecutive cycles of synchronised supply-good, saturating.
  logic [RUN_W-1:0] good_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                good_run_q <= '0;
    else if (!supply_ok)                       good_run_q <= '0;
    else if (good_run_q != RUN_W'(HOLD_CYCLES)) good_run_q <= good_run_q + 1'b1;
  end

  // R2: release only after a full unbroken hold interval of supply-good
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> (good_run_q == RUN_W'(HOLD_CYCLES)));

endmodule

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;

  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic wdog = 1'b0;
  logic fset = 1'b0;
  logic fclr = 1'b0;

  logic rst_lo, inhibit, flag;
  logic rst_hi, inhibit_hi, flag_hi;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  supply_reset_seq #(.HOLD_CYCLES(HOLD), .RST_ACTIVE_LOW(1'b1)) i_supply_reset_seq (
    .clk(clk), .rst_n(rst_n), .supply_good_i(supply_good), .wdog_expire_i(wdog),
    .flag_set_i(fset), .flag_clr_i(fclr),
    .sys_rst_o(rst_lo), .cmd_inhibit_o(inhibit), .cause_flag_o(flag));

  supply_reset_seq #(.HOLD_CYCLES(HOLD), .RST_ACTIVE_LOW(1'b0)) i_supply_reset_seq_hi (
    .clk(clk), .rst_n(rst_n), .supply_good_i(supply_good), .wdog_expire_i(wdog),
    .flag_set_i(fset), .flag_clr_i(fclr),
    .sys_rst_o(rst_hi), .cmd_inhibit_o(inhibit_hi), .cause_flag_o(flag_hi));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks R7 and R10 alongside the caller's requirement.
  task automatic expect_rst(input string req, input logic active);
    chk(req, {4'd0, rst_lo, rst_hi, inhibit, inhibit_hi},
             {4'd0, ~active, active, active, active});
  endtask

  task automatic t_power_up;
    // R4: asserted during and after power-on reset with supply low
    tick(3);
    expect_rst("R4 in reset", 1'b1);
    chk("R8 flag cleared", {7'd0, flag}, 8'd0);
    @(negedge clk) rst_n = 1'b1;
    tick(6);
    expect_rst("R4 supply low after reset", 1'b1);
  endtask

  task automatic t_release;
    // R2: release edge after a clean rise
    @(negedge clk) supply_good = 1'b1;
    tick(HOLD + 1);
    expect_rst("R2 before release", 1'b1);
    tick(1);
    expect_rst("R2 at release", 1'b0);
    tick(30);
    expect_rst("R2 stays released", 1'b0);
  endtask

  task automatic t_brownout;
    // R1: latency through the synchroniser and hold while low
    @(negedge clk) supply_good = 1'b0;
    tick(2);
    expect_rst("R1 not yet", 1'b0);
    tick(1);
    expect_rst("R1 asserted", 1'b1);
    tick(HOLD + 10);
    expect_rst("R1 held while low", 1'b1);
  endtask

  task automatic t_dropout;
    // R3: mid-count dropout restarts the count
    @(negedge clk) supply_good = 1'b1;
    tick(10);
    @(negedge clk) supply_good = 1'b0;
    @(negedge clk) supply_good = 1'b1;
    tick(HOLD + 1);
    expect_rst("R3 restarted count", 1'b1);
    tick(1);
    expect_rst("R3 release after restart", 1'b0);
  endtask

  task automatic t_flag;
    // R8: set, clear, and clear priority
    @(negedge clk) fset = 1'b1;
    @(negedge clk) fset = 1'b0;
    chk("R8 set", {7'd0, flag}, 8'd1);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    chk("R8 clear", {7'd0, flag}, 8'd0);
    @(negedge clk) fset = 1'b1;
    @(negedge clk) fset = 1'b0;
    @(negedge clk) begin fset = 1'b1; fclr = 1'b1; end
    @(negedge clk) begin fset = 1'b0; fclr = 1'b0; end
    chk("R8 clear wins", {7'd0, flag}, 8'd0);
    @(negedge clk) fset = 1'b1;
    @(negedge clk) fset = 1'b0;
    chk("R8 set again", {7'd0, flag_hi}, 8'd1);
  endtask

  task automatic t_wdog;
    // R5: one pulse holds reset exactly HOLD edges
    @(negedge clk) wdog = 1'b1;
    tick(1);
    expect_rst("R5 asserted", 1'b1);
    @(negedge clk) wdog = 1'b0;
    tick(HOLD - 1);
    expect_rst("R5 last held edge", 1'b1);
    tick(1);
    expect_rst("R5 released", 1'b0);
  endtask

  task automatic t_wdog_retrigger;
    // R6 with R9: second pulse restarts; clear strobe ignored during hold
    @(negedge clk) wdog = 1'b1;
    @(negedge clk) wdog = 1'b0;
    tick(9);
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
    @(negedge clk) wdog = 1'b1;
    tick(1);
    @(negedge clk) wdog = 1'b0;
    tick(HOLD - 1);
    expect_rst("R6 held after restart", 1'b1);
    tick(1);
    expect_rst("R6 released", 1'b0);
    chk("R9 flag kept", {7'd0, flag}, 8'd1);
  endtask

  task automatic t_reset_clears_flag;
    // R8 with R4: power-on reset clears the flag and re-asserts reset
    @(negedge clk) rst_n = 1'b0;
    tick(1);
    chk("R8 flag cleared by reset", {7'd0, flag}, 8'd0);
    expect_rst("R4 reset re-asserted", 1'b1);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    t_power_up();
    t_release();
    t_flag();
    t_wdog();
    t_wdog_retrigger();
    t_brownout();
    t_dropout();
    t_reset_clears_flag();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule